// File: doc/BRIEF.md
# Quad-I/O Page-Program Command Receiver

This block is the slave-side command front end of a serial flash device whose protocol carries every phase over four data lines. While chip select is low, it samples one nibble from the four data lines on each rising edge of the serial clock. Each pair of nibbles forms one byte, high nibble first. The first byte is the opcode. For a program command, a 24-bit or 32-bit address follows, and then any number of data bytes. Each data byte goes out on a registered page-buffer write port as an address and data pair, one cycle per byte.

A write-enable latch is kept here. A write-enable opcode sets it and a write-disable opcode clears it. A program command is refused while the latch is clear. When chip select rises, the block decides whether the program command is committed or discarded. It reports that decision with one pulse on one of two outputs. A committed program also clears the latch. The serial clock and chip select are oversampled by the block's own clock, so each serial clock phase must last at least one system clock period.

Top module: `qio_prog_rx`

## Requirements
- R1: A nibble is sampled from `dq` on each rising edge of `sck` while `cs_n` is low. The first nibble of a byte gives bits 7..4 and the second gives bits 3..0, with `dq[3]` as the most significant bit of each nibble.
- R2: Opcodes 8'h02, 8'h12 and 8'h32 are all decoded as the same page-program command, with identical writes and outcome.
- R3: `wel` is 0 after reset. Opcode 8'h06 sets it and opcode 8'h04 clears it.
- R4: A program opcode received while `wel` is 0 is ignored. No `pg_we` pulse, no commit and no abort follow, and `wel` stays 0.
- R5: When `addr4_mode` is 1 as the opcode completes, the address phase takes four bytes, most significant first. Otherwise it takes three bytes and `pg_addr[31:24]` is zero.
- R6: The first data byte is written at the received address. Each later byte goes to the next column, and the low 8 address bits wrap from 8'hFF to 8'h00 while bits 31..8 stay fixed.
- R7: If `cs_n` rises during the data phase on a byte boundary after at least one data byte, `prog_commit` pulses for one cycle and `wel` is cleared.
- R8: An accepted program that ends in any other way (inside the address phase, with no data byte, or with a partial byte) pulses `prog_abort` for one cycle, and `wel` stays 1.
- R9: An unknown opcode makes the block ignore every later nibble until `cs_n` rises. The next command is then decoded normally.
- R10: While `quad_mode` is 0, no opcode is recognised: `wel` is unchanged and no write is issued.
- R11: After reset, `pg_we`, `prog_commit`, `prog_abort` and `wel` are all 0.
- R12: `pg_we` is a one-cycle pulse per data byte and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| quad_mode | input | 1 | Device is in four-line protocol mode |
| addr4_mode | input | 1 | Use 32-bit addresses instead of 24-bit addresses |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| dq | input | 4 | Four serial data lines |
| pg_we | output | 1 | Page-buffer write strobe |
| pg_addr | output | 32 | Page-buffer write address |
| pg_data | output | 8 | Page-buffer write data |
| prog_commit | output | 1 | Program command committed (pulse) |
| prog_abort | output | 1 | Accepted program command discarded (pulse) |
| wel | output | 1 | Write-enable latch |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 8-bit bytes, 4-bit nibbles and a 256-byte page. With these values, both address widths can be reached just by toggling `addr4_mode`. A start column of 8'hFE brings the page wrap within four data bytes. The serial clock is held for two system cycles per phase, so each byte takes several system cycles. This exposes the one-cycle write pulse and leaves room to raise chip select between nibbles, which creates the partial-byte case.

// File: rtl/qio_pkg.sv
package qio_pkg;
  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } qio_state_e;

  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_WRDI   = 8'h04;
  localparam logic [7:0] OPC_PROG_A = 8'h02;
  localparam logic [7:0] OPC_PROG_B = 8'h12;
  localparam logic [7:0] OPC_PROG_C = 8'h32;
endpackage

// File: rtl/qio_edge_detect.sv
module qio_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic cs_rise
);
  logic sck_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  // serial clock edges only count inside a selected frame
  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/qio_byte_asm.sv
module qio_byte_asm #(
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic [NIB_W-1:0]  dq,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val,
  output logic              mid_byte
);
  localparam int NIBS  = BYTE_W / NIB_W;
  localparam int ACC_W = BYTE_W - NIB_W;
  localparam int CNT_W = (NIBS > 2) ? $clog2(NIBS) : 1;

  logic [CNT_W-1:0] nib_cnt;
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_cnt  <= '0;
      byte_stb <= 1'b0;
      byte_val <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (cs_n) begin
        nib_cnt <= '0;
      end else if (sck_rise) begin
        if (nib_cnt == CNT_W'(NIBS - 1)) begin
          nib_cnt  <= '0;
          byte_val <= {acc, dq};
          byte_stb <= 1'b1;
        end else begin
          nib_cnt <= nib_cnt + CNT_W'(1);
        end
      end
    end
  end

  generate
    if (ACC_W > NIB_W) begin : g_wide_acc
      always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else if (sck_rise) acc <= {acc[ACC_W-NIB_W-1:0], dq};
      end
    end else begin : g_single_acc
      always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else if (sck_rise) acc <= dq;
      end
    end
  endgenerate

  assign mid_byte = (nib_cnt != '0);
endmodule

// File: rtl/qio_addr_unit.sv
module qio_addr_unit #(
  parameter int ADDR_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int PAGE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic              inc,
  input  logic [BYTE_W-1:0] din,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      addr <= '0;
    end else if (load) begin
      addr <= {addr[ADDR_W-BYTE_W-1:0], din};
    end else if (inc) begin
      // column advances inside the page, upper bits held
      addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + PAGE_BITS'(1);
    end
  end
endmodule

// File: rtl/qio_cmd_fsm.sv
module qio_cmd_fsm
  import qio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              quad_mode,
  input  logic              addr4_mode,
  input  logic              cs_rise,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              mid_byte,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              addr_clr,
  output logic              addr_load,
  output logic              addr_inc,
  output logic              pg_we,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [BYTE_W-1:0] pg_data,
  output logic              prog_commit,
  output logic              prog_abort,
  output logic              wel
);
  localparam int WIDE_BYTES   = ADDR_W / BYTE_W;
  localparam int NARROW_BYTES = WIDE_BYTES - 1;
  localparam int CNT_W        = $clog2(WIDE_BYTES + 1);

  qio_state_e       state;
  logic [CNT_W-1:0] addr_left;
  logic             got_data;
  logic             is_prog;

  assign is_prog = (byte_val == BYTE_W'(OPC_PROG_A)) ||
                   (byte_val == BYTE_W'(OPC_PROG_B)) ||
                   (byte_val == BYTE_W'(OPC_PROG_C));

  always_comb begin
    addr_clr  = 1'b0;
    addr_load = 1'b0;
    addr_inc  = 1'b0;
    if (!cs_rise && byte_stb) begin
      case (state)
        ST_OPC:  addr_clr  = 1'b1;
        ST_ADDR: addr_load = 1'b1;
        ST_DATA: addr_inc  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OPC;
      addr_left   <= '0;
      got_data    <= 1'b0;
      wel         <= 1'b0;
      pg_we       <= 1'b0;
      pg_addr     <= '0;
      pg_data     <= '0;
      prog_commit <= 1'b0;
      prog_abort  <= 1'b0;
    end else begin
      pg_we       <= 1'b0;
      prog_commit <= 1'b0;
      prog_abort  <= 1'b0;
      if (cs_rise) begin
        if (state == ST_DATA && got_data && !mid_byte) begin
          prog_commit <= 1'b1;
          wel         <= 1'b0;
        end else if (state == ST_ADDR || state == ST_DATA) begin
          prog_abort <= 1'b1;
        end
        state    <= ST_OPC;
        got_data <= 1'b0;
      end else if (byte_stb) begin
        case (state)
          ST_OPC: begin
            state <= ST_SKIP;
            if (quad_mode) begin
              if (byte_val == BYTE_W'(OPC_WREN)) begin
                wel <= 1'b1;
              end else if (byte_val == BYTE_W'(OPC_WRDI)) begin
                wel <= 1'b0;
              end else if (is_prog && wel) begin
                state     <= ST_ADDR;
                addr_left <= addr4_mode ? CNT_W'(WIDE_BYTES - 1)
                                        : CNT_W'(NARROW_BYTES - 1);
              end
            end
          end
          ST_ADDR: begin
            if (addr_left == '0) state <= ST_DATA;
            else addr_left <= addr_left - CNT_W'(1);
          end
          ST_DATA: begin
            pg_we    <= 1'b1;
            pg_addr  <= cur_addr;
            pg_data  <= byte_val;
            got_data <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qio_prog_rx.sv
module qio_prog_rx #(
  parameter int ADDR_W    = 32,
  parameter int NIB_W     = 4,
  parameter int BYTE_W    = 8,
  parameter int PAGE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              quad_mode,
  input  logic              addr4_mode,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [NIB_W-1:0]  dq,
  output logic              pg_we,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [BYTE_W-1:0] pg_data,
  output logic              prog_commit,
  output logic              prog_abort,
  output logic              wel
);
  logic              sck_rise;
  logic              cs_rise;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;
  logic              mid_byte;
  logic              addr_clr;
  logic              addr_load;
  logic              addr_inc;
  logic [ADDR_W-1:0] cur_addr;

  qio_edge_detect u_edge (
    .clk      (clk),
    .rst      (rst),
    .sck      (sck),
    .cs_n     (cs_n),
    .sck_rise (sck_rise),
    .cs_rise  (cs_rise)
  );

  qio_byte_asm #(.NIB_W(NIB_W), .BYTE_W(BYTE_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck_rise (sck_rise),
    .dq       (dq),
    .byte_stb (byte_stb),
    .byte_val (byte_val),
    .mid_byte (mid_byte)
  );

  qio_addr_unit #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .PAGE_BITS(PAGE_BITS)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .clr  (addr_clr),
    .load (addr_load),
    .inc  (addr_inc),
    .din  (byte_val),
    .addr (cur_addr)
  );

  qio_cmd_fsm #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .quad_mode   (quad_mode),
    .addr4_mode  (addr4_mode),
    .cs_rise     (cs_rise),
    .byte_stb    (byte_stb),
    .byte_val    (byte_val),
    .mid_byte    (mid_byte),
    .cur_addr    (cur_addr),
    .addr_clr    (addr_clr),
    .addr_load   (addr_load),
    .addr_inc    (addr_inc),
    .pg_we       (pg_we),
    .pg_addr     (pg_addr),
    .pg_data     (pg_data),
    .prog_commit (prog_commit),
    .prog_abort  (prog_abort),
    .wel         (wel)
  );
endmodule

// File: rtl/qio_prog_rx_chk.sv
module qio_prog_rx_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              pg_we,
  input logic [ADDR_W-1:0] pg_addr,
  input logic              prog_commit,
  input logic              prog_abort,
  input logic              wel
);
  logic              have_last;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      have_last <= 1'b0;
      last_addr <= '0;
    end else if (pg_we) begin
      have_last <= 1'b1;
      last_addr <= pg_addr;
    end
  end

  always @(posedge clk) begin
    if (!rst && !cs_n && pg_we && have_last)
      AST_ADDR_SEQ: assert (pg_addr == {last_addr[ADDR_W-1:PAGE_BITS],
                                        last_addr[PAGE_BITS-1:0] + PAGE_BITS'(1)})
        else $error("write address not sequential"); // R6
  end

  AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    pg_we |-> wel) else $error("write without latch"); // R4
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pg_we |=> !pg_we) else $error("write strobe too long"); // R12
  AST_COMMIT_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
    prog_commit |-> !wel) else $error("latch kept after commit"); // R7
  AST_ABORT_KEEPS_WEL: assert property (@(posedge clk) disable iff (rst)
    prog_abort |=> wel) else $error("latch lost on abort"); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(prog_commit && prog_abort)) else $error("commit and abort together"); // R7
endmodule

bind qio_prog_rx qio_prog_rx_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n        (cs_n),
  .pg_we       (pg_we),
  .pg_addr     (pg_addr),
  .prog_commit (prog_commit),
  .prog_abort  (prog_abort),
  .wel         (wel)
);

// File: tb/qio_prog_rx_bench.sv
`timescale 1ns/1ps
module qio_prog_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        quad_mode = 1'b1;
  logic        addr4_mode = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic [3:0]  dq = 4'h0;
  logic        pg_we;
  logic [31:0] pg_addr;
  logic [7:0]  pg_data;
  logic        prog_commit;
  logic        prog_abort;
  logic        wel;

  always #2 clk = ~clk;

  qio_prog_rx u_qio_prog_rx (
    .clk(clk), .rst(rst), .quad_mode(quad_mode), .addr4_mode(addr4_mode),
    .cs_n(cs_n), .sck(sck), .dq(dq), .pg_we(pg_we), .pg_addr(pg_addr),
    .pg_data(pg_data), .prog_commit(prog_commit), .prog_abort(prog_abort), .wel(wel)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;
  string cur_tag = "R11";
  logic [39:0] exp_q[$];
  logic [7:0]  payload[$];
  bit m_wel = 0;
  int exp_commit = 0, exp_abort = 0, seen_commit = 0, seen_abort = 0;
  logic prev_we = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (pg_we) begin
        chk({cur_tag, " R12 strobe gap"}, 64'(prev_we), 64'd0);
        if (exp_q.size() == 0) begin
          chk({cur_tag, " unexpected write"}, 64'd1, 64'd0);
        end else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk({cur_tag, " write addr"}, 64'(pg_addr), 64'(e[39:8]));
          chk({cur_tag, " R1 write data"}, 64'(pg_data), 64'(e[7:0]));
        end
      end
      if (prog_commit) seen_commit++;
      if (prog_abort) seen_abort++;
      prev_we = pg_we;
    end
  end

  task automatic nib(input logic [3:0] v);
    @(negedge clk); sck = 1'b0; dq = v;
    @(negedge clk);
    @(negedge clk); sck = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    nib(b[7:4]);
    nib(b[3:0]);
  endtask

  function automatic bit is_prog(input logic [7:0] op);
    return op == 8'h02 || op == 8'h12 || op == 8'h32;
  endfunction

  // one framed command; payload queue holds the bytes after the address
  task automatic xfer(input string tag, input logic [7:0] op, input logic a4,
                      input logic [31:0] addr, input bit extra);
    logic [31:0] base;
    bit accept;
    cur_tag = tag;
    addr4_mode = a4;
    base = a4 ? addr : {8'h00, addr[23:0]};
    accept = quad_mode && is_prog(op) && m_wel;
    if (quad_mode && op == 8'h06) m_wel = 1;
    if (quad_mode && op == 8'h04) m_wel = 0;
    if (accept) begin
      foreach (payload[i]) begin
        logic [7:0] col;
        col = base[7:0] + 8'(i);
        exp_q.push_back({base[31:8], col, payload[i]});
      end
      if (payload.size() > 0 && !extra) begin exp_commit++; m_wel = 0; end
      else exp_abort++;
    end
    @(negedge clk); cs_n = 1'b0; sck = 1'b0;
    @(negedge clk);
    send_byte(op);
    if (is_prog(op)) begin
      if (a4) send_byte(addr[31:24]);
      send_byte(addr[23:16]);
      send_byte(addr[15:8]);
      send_byte(addr[7:0]);
    end
    foreach (payload[i]) send_byte(payload[i]);
    if (extra) nib(4'hA);
    @(negedge clk); sck = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({tag, " wel"}, 64'(wel), 64'(m_wel));
    chk({tag, " commit count"}, 64'(seen_commit), 64'(exp_commit));
    chk({tag, " abort count"}, 64'(seen_abort), 64'(exp_abort));
    chk({tag, " pending writes"}, 64'(exp_q.size()), 64'd0);
    payload.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 pg_we", 64'(pg_we), 64'd0);
    chk("R11 wel", 64'(wel), 64'd0);
    chk("R11 commit", 64'(prog_commit), 64'd0);
    chk("R11 abort", 64'(prog_abort), 64'd0);

    payload = '{8'h11, 8'h22};
    xfer("R4 program without latch", 8'h02, 1'b0, 32'h0000_1000, 0);

    xfer("R3 set latch", 8'h06, 1'b0, 32'h0, 0);
    xfer("R3 clear latch", 8'h04, 1'b0, 32'h0, 0);
    xfer("R3 set latch again", 8'h06, 1'b0, 32'h0, 0);

    payload = '{8'hA5, 8'h3C, 8'h0F};
    xfer("R7 R5 R1 program 02 narrow", 8'h02, 1'b0, 32'h7712_3456, 0);

    xfer("R3 latch", 8'h06, 1'b0, 32'h0, 0);
    payload = '{8'h01, 8'h02, 8'h03, 8'h04};
    xfer("R2 R5 R6 program 12 wide wrap", 8'h12, 1'b1, 32'h89AB_CDFE, 0);

    xfer("R3 latch", 8'h06, 1'b0, 32'h0, 0);
    payload = '{8'hF0, 8'h5A};
    xfer("R2 program 32", 8'h32, 1'b0, 32'h0000_FF10, 0);

    xfer("R3 latch", 8'h06, 1'b0, 32'h0, 0);
    payload = '{8'hC3};
    xfer("R8 partial byte", 8'h02, 1'b0, 32'h0004_0020, 1);
    xfer("R8 no data", 8'h02, 1'b1, 32'h1234_5678, 0);

    payload = '{8'h02, 8'h00, 8'h00, 8'h00, 8'h55};
    xfer("R9 unknown opcode", 8'h9F, 1'b0, 32'h0, 0);
    payload = '{8'h99};
    xfer("R9 recovery", 8'h02, 1'b0, 32'h0000_0300, 0);

    quad_mode = 1'b0;
    xfer("R10 set latch ignored", 8'h06, 1'b0, 32'h0, 0);
    quad_mode = 1'b1;
    xfer("R3 latch", 8'h06, 1'b0, 32'h0, 0);
    quad_mode = 1'b0;
    payload = '{8'h77};
    xfer("R10 program ignored", 8'h02, 1'b0, 32'h0000_0500, 0);
    xfer("R10 clear ignored", 8'h04, 1'b0, 32'h0, 0);
    quad_mode = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule